// File: doc/BRIEF.md
# Single-Port Static RAM with Per-Bit Write Mask

This block is a synchronous single-port memory with a configurable number of words and bits per word. Input and output data travel on separate buses. One rising clock edge performs exactly one operation, chosen by an active-low select, an active-low write strobe and an active-low per-bit mask. The operation is a whole-word write, a partial write, a no-operation or a read. Deselecting the block puts it in standby: stored words are kept and the output does not move.

Read data is captured in an output register and shows up after the clock edge that performed the read. Write cycles and standby cycles leave that register untouched, so the output keeps showing the last word that was read. A separate active-low output enable switches the output bus to high impedance at once, without waiting for a clock edge. Addresses at or above the word count are outside the array. Writes to them are discarded and reads from them return an undefined value.

Top module: `bitmask_sram`

## Requirements
- R1: While reset is asserted, and after it is released, the output register holds all zeros until the first read.
- R2: With select low, write low and every mask bit low, the full input word is stored at the given address.
- R3: With select low and write low, each data bit whose mask bit is low is stored. Each stored bit whose mask bit is high keeps its old value.
- R4: A write cycle with every mask bit high changes no stored bit.
- R5: On a write cycle the output keeps the value it showed before the cycle.
- R6: With select low and write high, the word at the address appears on the output after that clock edge. No further cycle of delay is added.
- R7: With select high, address, data, write and mask are ignored. The memory keeps its contents and the output holds its value.
- R8: With output enable high, every output bit is high impedance at once. With it low, the output shows the output register.
- R9: A write to an address at or beyond the word count changes no word that is inside the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all operations happen on its rising edge |
| rstN | input | 1 | Active-low reset of the output register |
| selN | input | 1 | Active-low chip select; high means standby |
| wrN | input | 1 | Active-low write strobe; high means read |
| maskN | input | WIDTH | Active-low per-bit write enable |
| outEnN | input | 1 | Active-low asynchronous output enable |
| addr | input | AW = clog2(DEPTH) | Word address |
| dataIn | input | WIDTH | Write data |
| dataOut | output | WIDTH | Read data, or high impedance |

## Verification
A read is due on the output in the half cycle that follows the edge that performed it. Write and standby cycles are due to leave that same value in place. The driver computes one expected output word for every edge it drives and places it in a queue. The monitor takes the word out at the next falling edge, after the single register stage has updated and well before the next rising edge. The output-enable check works without the clock: the bench toggles the enable between edges and samples one time unit later.

// File: rtl/sram_pkg.sv
package sram_pkg;

  // Per-edge command from control to datapath.
  typedef struct packed {
    logic wrEn;   // commit masked write this edge
    logic rdEn;   // load output register this edge
  } sramCtl_t;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 200,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 selN,
  input  logic                 wrN,
  input  logic [WIDTH-1:0]     maskN,
  input  logic [AW-1:0]        addr,
  output logic                 inRange,
  output sram_pkg::sramCtl_t   ctl
);

  localparam int FULL = (1 << AW);

  generate
    if (DEPTH == FULL) begin : g_pow2
      assign inRange = 1'b1;
    end else begin : g_partial
      assign inRange = (addr < AW'(DEPTH));
    end
  endgenerate

  logic anyBit;
  assign anyBit = ~(&maskN);

  always_comb begin
    ctl.wrEn = ~selN & ~wrN & anyBit & inRange;
    ctl.rdEn = ~selN & wrN;
  end

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 200,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sram_pkg::sramCtl_t   ctl,
  input  logic                 inRange,
  input  logic [WIDTH-1:0]     maskN,
  input  logic [AW-1:0]        addr,
  input  logic [WIDTH-1:0]     dataIn,
  output logic [WIDTH-1:0]     readQ
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Storage has no reset: contents start unknown.
  always_ff @(posedge clk) begin
    if (ctl.wrEn)
      mem[addr] <= (mem[addr] & maskN) | (dataIn & ~maskN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      readQ <= '0;
    else if (ctl.rdEn)
      readQ <= inRange ? mem[addr] : {WIDTH{1'bx}};
  end

endmodule

// File: rtl/bitmask_sram.sv
module bitmask_sram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 200,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selN,
  input  logic             wrN,
  input  logic [WIDTH-1:0] maskN,
  input  logic             outEnN,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);

  sram_pkg::sramCtl_t ctl;
  logic               inRange;
  logic [WIDTH-1:0]   readQ;

  sram_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .selN(selN), .wrN(wrN), .maskN(maskN), .addr(addr),
    .inRange(inRange), .ctl(ctl)
  );

  sram_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inRange(inRange),
    .maskN(maskN), .addr(addr), .dataIn(dataIn), .readQ(readQ)
  );

  assign dataOut = outEnN ? {WIDTH{1'bz}} : readQ;

endmodule

// File: rtl/bitmask_sram_chk.sv
module bitmask_sram_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 200,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             selN,
  input logic             wrN,
  input logic [WIDTH-1:0] maskN,
  input logic             outEnN,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] readQ,
  input logic [WIDTH-1:0] dataOut
);

  // R5: a write cycle leaves the output register alone
  p_write_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !wrN) |=> $stable(readQ));

  // R7: standby holds the output register
  p_standby_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    selN |=> $stable(readQ));

  // R8: an enabled output follows the output register
  p_drive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !outEnN |-> (dataOut == readQ));

  // R2, R6: full-word write followed by a read of that address returns it
  p_write_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !wrN && maskN == '0 && addr < AW'(DEPTH))
      ##1 (!selN && wrN && addr == $past(addr))
    |=> (readQ == $past(dataIn, 2)));

endmodule

bind bitmask_sram bitmask_sram_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN), .maskN(maskN),
  .outEnN(outEnN), .addr(addr), .dataIn(dataIn), .readQ(readQ),
  .dataOut(dataOut)
);

// File: tb/bitmask_sram_test.sv
module bitmask_sram_test;

  localparam int W     = 16;
  localparam int D     = 200;
  localparam int AW    = $clog2(D);
  localparam int HALF  = 4;   // 125 MHz

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          selN = 1'b1;
  logic          wrN = 1'b1;
  logic [W-1:0]  maskN = '1;
  logic          outEnN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  dataIn = '0;
  wire  [W-1:0]  dataOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bitmask_sram #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN), .maskN(maskN),
    .outEnN(outEnN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut)
  );

  always #HALF clk = ~clk;

  typedef struct {
    logic [W-1:0] val;
    string        req;
  } expItem_t;

  expItem_t     sbq[$];
  logic [W-1:0] refMem [D];
  logic [W-1:0] expQ = '0;

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one edge, one expected output word.
  task automatic op(input logic s, input logic w, input logic [W-1:0] m,
                    input int a, input logic [W-1:0] d, input string req);
    expItem_t it;
    @(negedge clk);
    selN = s; wrN = w; maskN = m; addr = AW'(a); dataIn = d;
    @(posedge clk);
    if (!s) begin
      if (!w) begin
        if (a < D) refMem[a] = (refMem[a] & m) | (d & ~m);
      end else if (a < D) begin
        expQ = refMem[a];
      end
    end
    it.val = expQ;
    it.req = req;
    sbq.push_back(it);
  endtask

  task automatic wr(input int a, input logic [W-1:0] d, input logic [W-1:0] m,
                    input string req);
    op(1'b0, 1'b0, m, a, d, req);
  endtask

  task automatic rd(input int a, input string req);
    op(1'b0, 1'b1, '1, a, '0, req);
  endtask

  // Monitor: compare at the falling edge after each driven edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        expItem_t it;
        it = sbq.pop_front();
        check(it.req, dataOut, it.val);
      end
    end
  end

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", dataOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", dataOut, '0);

    // R2: full-word writes over a range, read back
    for (int i = 0; i < 12; i++) wr(i * 17, W'(16'hA5A5 ^ (i * 16'h1111)), '0, "R5 hold on write");
    wr(D - 1, 16'h7E81, '0, "R5 hold on write");
    for (int i = 0; i < 12; i++) rd(i * 17, "R2 R6 full write readback");
    rd(D - 1, "R2 R6 top address");

    // R5: write right after a read keeps the read value
    rd(0, "R6 read");
    wr(0, 16'hFFFF, '0, "R5 output hold during write");
    rd(0, "R2 overwrite");

    // R3: partial writes with several masks
    wr(17, 16'h1234, 16'hFF00, "R5 hold on masked write");
    rd(17, "R3 low byte masked write");
    wr(34, 16'hFFFF, 16'h5555, "R5 hold on masked write");
    rd(34, "R3 alternating mask");
    wr(51, 16'h0000, 16'h7FFE, "R5 hold on masked write");
    rd(51, "R3 edge bits only");

    // R4: all mask bits high is a no-op
    wr(68, 16'hDEAD, '1, "R5 hold on no-op");
    rd(68, "R4 all-high mask no-op");

    // R7: standby ignores everything
    rd(85, "R6 read before standby");
    op(1'b1, 1'b0, '0, 85, 16'hBEEF, "R7 output holds in standby");
    op(1'b1, 1'b1, '0, 102, 16'hBEEF, "R7 standby read ignored");
    rd(85, "R7 contents kept through standby");

    // R9: out-of-range write changes no in-range word
    wr(250, 16'h0F0F, '0, "R5 hold on out-of-range write");
    rd(50 + 0, "R9 word 50 (unwritten check via known)");
    wr(50, 16'h3C3C, '0, "R5 hold");
    wr(122, 16'hC3C3, '0, "R5 hold");
    wr(250, 16'h0F0F, '0, "R5 hold on out-of-range write");
    rd(50, "R9 word 50 unchanged");
    rd(122, "R9 word 122 unchanged");

    // drain scoreboard
    @(negedge clk);
    @(negedge clk);

    // R8: asynchronous high impedance
    #1 outEnN = 1'b1;
    #1;
    checks++;
    if (dataOut !== {W{1'bz}}) begin
      failures++;
      $display("FAIL R8 actual=%h expected=%h", dataOut, {W{1'bz}});
    end
    #1 outEnN = 1'b0;
    #1;
    check("R8 drive restored", dataOut, expQ);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule